// File: doc/BRIEF.md
# DDS Serial Configuration Loader

This block drives the three-wire serial programming port of a direct digital synthesis device from inside a larger chip. A host hands it a precomputed 32-bit tuning word, a reference-multiplier enable flag and a 5-bit phase step (in 11.25 degree units) with a single-cycle start request. The block packs these into a 40-bit frame and shifts it out on a data line under a word clock. It then pulses a load strobe so that the device takes up the new word. A second request runs the short wake-up pattern that puts the device into serial-load mode.

Every phase of the serial waveform lasts `PHASE_CLKS` system clocks, so the port can be slowed down to suit board wiring. `ready_o` shows that a request will be accepted. `busy_o` covers the whole operation, and `done_o` pulses for one cycle when the lines have returned low.

The controller is a state machine with six states. `IDLE` holds all lines low and accepts requests, and a start request takes priority over an enable request. `BIT_SETUP` presents the current frame bit with the word clock low. `BIT_HIGH` raises the word clock. `BIT_HOLD` lowers the clock while keeping the data, then either shifts the frame and returns to `BIT_SETUP`, or moves to `LOAD` after the 40th bit. `LOAD` raises the load strobe for one phase and returns to `IDLE`, emitting done. `ENABLE_SEQ` walks four phases (low, word clock high, low, load high) and returns to `IDLE`, emitting done.

Top module: `dds_serial_loader`

## Requirements
- R1: While reset is asserted and immediately after it, `ready_o` is 1, and `busy_o`, `done_o`, `sdata_o`, `wclk_o` and `load_o` are all 0.
- R2: An accepted start sends exactly 40 bits, one word-clock rising edge per bit. The 32 tuning-word bits go first, least significant first, and the 8 control bits follow, least significant first. Each bit is the value of `sdata_o` at the word-clock rising edge.
- R3: Control bit 0 carries `mult_en_i`, bits 2:1 are 0, and bits 7:3 carry `phase_step_i` (bit 3 is its LSB).
- R4: Each bit takes three phases of `PHASE_CLKS` cycles each: setup with the clock low, clock high, hold with the clock low. The word clock stays high exactly `PHASE_CLKS` cycles, and `sdata_o` does not change while it is high. The first rising edge comes `PHASE_CLKS` cycles after `busy_o` rises.
- R5: After the 40th bit, `load_o` goes high exactly once, for `PHASE_CLKS` cycles, `120*PHASE_CLKS` cycles after `busy_o` rose. The word clock and data stay low while it is high.
- R6: `busy_o` stays high for `121*PHASE_CLKS` cycles per transfer. `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls. `ready_o` is the inverse of `busy_o`.
- R7: Start and enable requests that arrive while busy are ignored. The frame in progress is sent unchanged and only one done pulse follows.
- R8: An enable request in idle produces one word-clock pulse starting `PHASE_CLKS` cycles after `busy_o` rises, then one load pulse starting `3*PHASE_CLKS` cycles after. Busy lasts `4*PHASE_CLKS` cycles and ends with one done pulse.
- R9: If start and enable requests arrive in the same idle cycle, the data transfer is performed.
- R10: `sdata_o` is low whenever no bit is being transferred: in idle, during the load strobe and throughout the enable sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a frame transfer (sampled in idle) |
| enable_seq_i | input | 1 | Request the serial-mode enable sequence |
| tuning_word_i | input | 32 | Precomputed frequency tuning word |
| mult_en_i | input | 1 | Reference multiplier enable flag |
| phase_step_i | input | 5 | Phase offset in 11.25 degree steps |
| ready_o | output | 1 | Block is idle and will accept a request |
| busy_o | output | 1 | Transfer or enable sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sdata_o | output | 1 | Serial data line |
| wclk_o | output | 1 | Word clock line |
| load_o | output | 1 | Load strobe line |

## Verification
The bench decodes the serial lines the way the device would, taking data at each word-clock rising edge. A wrong bit order or a misplaced control field therefore shows up as a wrong decoded frame, and alternating and all-ones words expose a shift in the wrong direction. The bench counts phase lengths and the cycle offsets of the first clock and of the load pulse, which catches an off-by-one phase counter or a frame cut short or stretched to 39 or 41 bits. Requests injected mid-transfer catch a design that reloads the frame or restarts, because a corrupted frame or a second done pulse would follow. A simultaneous start and enable request catches reversed priority, which would show one clock pulse instead of forty.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;

    localparam int WORD_W  = 32;
    localparam int CTRL_W  = 8;
    localparam int PHASE_W = 5;
    localparam int FRAME_W = WORD_W + CTRL_W;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_BIT_SETUP  = 3'd1,
        ST_BIT_HIGH   = 3'd2,
        ST_BIT_HOLD   = 3'd3,
        ST_LOAD       = 3'd4,
        ST_ENABLE_SEQ = 3'd5
    } ldr_state_e;

    // multiplier flag at bit 0, bits 2:1 reserved zero, phase step at 7:3
    function automatic logic [CTRL_W-1:0] pack_ctrl(input logic mult,
                                                    input logic [PHASE_W-1:0] phase);
        return {phase, 2'b00, mult};
    endfunction

endpackage

// File: rtl/dds_phase_timer.sv
module dds_phase_timer #(
    parameter int PHASE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dds_frame_shifter.sv
module dds_frame_shifter #(
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    output logic               lsb_o,
    output logic               last_o
);
    localparam int BCW = $clog2(FRAME_W);
    localparam logic [BCW-1:0] LAST_IDX = BCW'(FRAME_W - 1);

    logic [FRAME_W-1:0] sreg_q;
    logic [BCW-1:0]     idx_q;

    assign lsb_o  = sreg_q[0];
    assign last_o = (idx_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= frame_i;
            idx_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
            idx_q  <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/dds_loader_fsm.sv
module dds_loader_fsm
    import dds_loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic enable_seq_i,
    input  logic tick_i,
    input  logic last_bit_i,
    input  logic bit_i,
    output logic load_frame_o,
    output logic shift_o,
    output logic run_o,
    output logic ready_o,
    output logic busy_o,
    output logic done_o,
    output logic sdata_o,
    output logic wclk_o,
    output logic load_o
);
    ldr_state_e state_q, state_d;
    logic [1:0] step_q, step_d;
    logic       done_q, done_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step_d = 2'd0;
                if (start_i)           state_d = ST_BIT_SETUP;
                else if (enable_seq_i) state_d = ST_ENABLE_SEQ;
            end
            ST_BIT_SETUP: if (tick_i) state_d = ST_BIT_HIGH;
            ST_BIT_HIGH:  if (tick_i) state_d = ST_BIT_HOLD;
            ST_BIT_HOLD: begin
                if (tick_i) state_d = last_bit_i ? ST_LOAD : ST_BIT_SETUP;
            end
            ST_LOAD: begin
                if (tick_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_ENABLE_SEQ: begin
                if (tick_i) begin
                    if (step_q == 2'd3) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        step_d = step_q + 2'd1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= 2'd0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        sdata_o      = 1'b0;
        wclk_o       = 1'b0;
        load_o       = 1'b0;
        shift_o      = 1'b0;
        load_frame_o = 1'b0;
        unique case (state_q)
            ST_IDLE:       load_frame_o = start_i;
            ST_BIT_SETUP:  sdata_o = bit_i;
            ST_BIT_HIGH: begin
                sdata_o = bit_i;
                wclk_o  = 1'b1;
            end
            ST_BIT_HOLD: begin
                sdata_o = bit_i;
                shift_o = tick_i && !last_bit_i;
            end
            ST_LOAD:       load_o = 1'b1;
            ST_ENABLE_SEQ: begin
                wclk_o = (step_q == 2'd1);
                load_o = (step_q == 2'd3);
            end
            default: ;
        endcase
        run_o   = (state_q != ST_IDLE);
        busy_o  = run_o;
        ready_o = !run_o;
        done_o  = done_q;
    end
endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
    import dds_loader_pkg::*;
#(
    parameter int PHASE_CLKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               enable_seq_i,
    input  logic [WORD_W-1:0]  tuning_word_i,
    input  logic               mult_en_i,
    input  logic [PHASE_W-1:0] phase_step_i,
    output logic               ready_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               sdata_o,
    output logic               wclk_o,
    output logic               load_o
);
    logic tick, run, load_frame, shift, lsb, last_bit;
    logic [FRAME_W-1:0] frame;

    assign frame = {pack_ctrl(mult_en_i, phase_step_i), tuning_word_i};

    dds_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    dds_frame_shifter #(.FRAME_W(FRAME_W)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_frame),
        .frame_i (frame),
        .shift_i (shift),
        .lsb_o   (lsb),
        .last_o  (last_bit)
    );

    dds_loader_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .enable_seq_i (enable_seq_i),
        .tick_i       (tick),
        .last_bit_i   (last_bit),
        .bit_i        (lsb),
        .load_frame_o (load_frame),
        .shift_o      (shift),
        .run_o        (run),
        .ready_o      (ready_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .sdata_o      (sdata_o),
        .wclk_o       (wclk_o),
        .load_o       (load_o)
    );
endmodule

// File: rtl/dds_serial_loader_chk.sv
module dds_serial_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic ready_o,
    input logic busy_o,
    input logic done_o,
    input logic sdata_o,
    input logic wclk_o,
    input logic load_o
);
    // R4: data holds while the word clock stays high
    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wclk_o && $past(wclk_o)) |-> $stable(sdata_o));

    // R5: load strobe never overlaps the clock or data
    assert_load_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (!wclk_o && !sdata_o));

    // R6: done is a single pulse right after busy ends
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_ready_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o != busy_o);

    // R10: all lines rest low while idle
    assert_idle_lines_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sdata_o && !wclk_o && !load_o));
endmodule

bind dds_serial_loader dds_serial_loader_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (ready_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sdata_o (sdata_o),
    .wclk_o  (wclk_o),
    .load_o  (load_o)
);

// File: tb/dds_serial_loader_tb_top.sv
`timescale 1ns/1ps
module dds_serial_loader_tb_top;
    localparam int P = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        enable_seq_i = 1'b0;
    logic [31:0] tuning_word_i = '0;
    logic        mult_en_i = 1'b0;
    logic [4:0]  phase_step_i = '0;
    logic ready_o, busy_o, done_o, sdata_o, wclk_o, load_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    dds_serial_loader #(.PHASE_CLKS(P)) dut_i (.*);

    // line monitor, sampled at falling edges
    int tcyc = 0;
    logic [63:0] cap;
    int nclk, nload, busy_cyc, done_cnt, stable_viol, data_outside;
    int hi_len, hi_min, hi_max, load_len, load_min, load_max;
    int t_busy, t_first_clk, t_load, clk_at_load;
    logic p_wclk = 0, p_load = 0, p_busy = 0, p_sdata = 0;

    task automatic clear_mon();
        cap = '0; nclk = 0; nload = 0; busy_cyc = 0; done_cnt = 0;
        stable_viol = 0; data_outside = 0; hi_len = 0; hi_min = 9999; hi_max = 0;
        load_len = 0; load_min = 9999; load_max = 0;
        t_busy = -1; t_first_clk = -1; t_load = -1; clk_at_load = -1;
    endtask

    always @(negedge clk) begin
        tcyc++;
        if (busy_o && !p_busy) t_busy = tcyc;
        if (busy_o) busy_cyc++;
        if (wclk_o && !p_wclk) begin
            if (nclk < 64) cap[nclk] = sdata_o;
            if (nclk == 0) t_first_clk = tcyc;
            nclk++;
            hi_len = 1;
        end else if (wclk_o) begin
            hi_len++;
            if (sdata_o != p_sdata) stable_viol++;
        end
        if (!wclk_o && p_wclk) begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
        end
        if (load_o && !p_load) begin
            nload++; t_load = tcyc; clk_at_load = nclk; load_len = 1;
        end else if (load_o) begin
            load_len++;
        end
        if (!load_o && p_load) begin
            if (load_len < load_min) load_min = load_len;
            if (load_len > load_max) load_max = load_len;
        end
        if (sdata_o && (!busy_o || load_o)) data_outside++;
        if (done_o) done_cnt++;
        p_wclk = wclk_o; p_load = load_o; p_busy = busy_o; p_sdata = sdata_o;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_end();
        int k = 0;
        while (!(done_cnt > 0 && !busy_o) && k < 3000) begin
            @(negedge clk); k++;
        end
        chk(k < 3000, "R6 completion timeout", k, 0);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [39:0] exp_frame(logic [31:0] w, logic m, logic [4:0] ph);
        return {ph, 2'b00, m, w};
    endfunction

    task automatic check_frame(input logic [39:0] ef, input int bcyc);
        chk(nclk == 40, "R2 clock count", nclk, 40);
        chk(cap[39:0] == ef, "R2/R3 decoded frame", cap[39:0], ef);
        chk(hi_min == P && hi_max == P, "R4 clock high width", hi_max, P);
        chk(stable_viol == 0, "R4 data stable while clock high", stable_viol, 0);
        chk(t_first_clk - t_busy == P, "R4 first clock offset", t_first_clk - t_busy, P);
        chk(nload == 1 && clk_at_load == 40, "R5 one load after 40th bit", clk_at_load, 40);
        chk(load_min == P && load_max == P, "R5 load width", load_max, P);
        chk(t_load - t_busy == 120 * P, "R5 load offset", t_load - t_busy, 120 * P);
        chk(busy_cyc == bcyc, "R6 busy length", busy_cyc, bcyc);
        chk(done_cnt == 1, "R6/R7 single done pulse", done_cnt, 1);
        chk(data_outside == 0, "R10 data low outside bits", data_outside, 0);
    endtask

    task automatic run_xfer(input logic [31:0] w, input logic m, input logic [4:0] ph);
        clear_mon();
        @(negedge clk);
        tuning_word_i = w; mult_en_i = m; phase_step_i = ph; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end();
        check_frame(exp_frame(w, m, ph), 121 * P);
        chk(ready_o && !busy_o, "R6 ready after transfer", ready_o, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ready_o && !busy_o && !done_o, "R1 status in reset", {ready_o, busy_o, done_o}, 3'b100);
        chk(!sdata_o && !wclk_o && !load_o, "R1 lines in reset", {sdata_o, wclk_o, load_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && !busy_o && !sdata_o && !wclk_o && !load_o, "R1 after release",
            {ready_o, busy_o, sdata_o, wclk_o, load_o}, 5'b10000);
    endtask

    task automatic test_ignore_busy();
        clear_mon();
        @(negedge clk);
        tuning_word_i = 32'h1234_5678; mult_en_i = 1'b1; phase_step_i = 5'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        tuning_word_i = 32'hDEAD_BEEF; mult_en_i = 1'b0; phase_step_i = 5'd22; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; enable_seq_i = 1'b1;
        @(negedge clk);
        enable_seq_i = 1'b0;
        repeat (100) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end();
        // R7: the first frame is sent unchanged
        check_frame(exp_frame(32'h1234_5678, 1'b1, 5'd9), 121 * P);
    endtask

    task automatic test_enable_seq();
        clear_mon();
        @(negedge clk);
        enable_seq_i = 1'b1;
        @(negedge clk);
        enable_seq_i = 1'b0;
        wait_end();
        chk(nclk == 1 && nload == 1, "R8 one clock and one load", {nclk, nload}, 64'h1_0000_0001);
        chk(t_first_clk - t_busy == P, "R8 clock offset", t_first_clk - t_busy, P);
        chk(t_load - t_busy == 3 * P, "R8 load offset", t_load - t_busy, 3 * P);
        chk(hi_max == P && load_max == P, "R8 pulse widths", hi_max, P);
        chk(busy_cyc == 4 * P && done_cnt == 1, "R8 busy length and done", busy_cyc, 4 * P);
        chk(data_outside == 0 && cap[0] == 1'b0, "R10 data low in enable sequence", data_outside, 0);
    endtask

    task automatic test_priority();
        clear_mon();
        @(negedge clk);
        tuning_word_i = 32'h0F0F_00FF; mult_en_i = 1'b0; phase_step_i = 5'd1;
        start_i = 1'b1; enable_seq_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; enable_seq_i = 1'b0;
        wait_end();
        chk(nclk == 40, "R9 transfer wins over enable", nclk, 40);
        chk(cap[39:0] == exp_frame(32'h0F0F_00FF, 1'b0, 5'd1), "R9 frame", cap[39:0],
            exp_frame(32'h0F0F_00FF, 1'b0, 5'd1));
    endtask

    initial begin
        clear_mon();
        test_reset();
        run_xfer(32'h0000_0001, 1'b1, 5'd0);
        run_xfer(32'hA5C3_3C5A, 1'b0, 5'd31);
        run_xfer(32'hFFFF_FFFF, 1'b1, 5'd5);
        run_xfer(32'h8000_0000, 1'b0, 5'd16);
        test_enable_seq();
        test_ignore_busy();
        test_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule